// File: doc/BRIEF.md
# Quadrature Divide-by-16 Unit

This block scales down the resolution of three incremental encoders. Each channel takes one two-bit quadrature pair. It produces a two-bit quadrature pair that steps one phase for every sixteen legal input phase steps. Motion in reverse walks the output back the same way. An extra index line is passed through and stretched, so that a short index pulse stays visible to a slower consumer.

All inputs go through a two-flop synchronizer. The synchronized values are looked at only on a periodic sample strobe that the block generates from `SAMPLE_DIV`. Each channel keeps a 6-bit position. The low four bits are a modulo-16 step count, and its two lowest bits hold the expected input phase. The top two bits step in Gray order and drive the output pair straight from a register. An input that repeats the current phase does not change the position. An input that jumps to the diagonal phase does not change it either, so an illegal jump is never counted.

Top module: `qdiv16_unit`

## Requirements
- R1: Channel c (0, 1, 2) reads input bits `quad_i[2c+1:2c]` and drives output bits `quad_o[2c+1:2c]`. A pair is read as the value {odd bit, even bit}.
- R2: The forward phase sequence of a pair is 00, 01, 11, 10, 00. An input one phase ahead of the expected phase counts one step up. After 16 forward steps the output pair moves one place forward in the same Gray sequence.
- R3: An input one phase behind the expected phase counts one step down. From reset, the first reverse step moves the output to 10. The output moves back again after 16 more reverse steps.
- R4: An input equal to the expected phase, or two phases from it, leaves the position unchanged. A later legal step is counted from the position that was held.
- R5: 64 forward steps bring an output pair back to 00, after it has passed through 01, 11 and 10.
- R6: While `rst_ni` is low, all outputs are 0 and every position is zero.
- R7: A sample that sees `index_i` high sets `index_o` on the next clock. `index_o` falls on the 32nd consecutive sample that sees the index low.
- R8: Inputs take effect only on the sample strobe, which fires once every `SAMPLE_DIV` clocks. An output changes only on the clock after a strobe. An input change shows up at the outputs no sooner than 3 clocks and no later than `2*SAMPLE_DIV+4` clocks after it is applied.
- R9: Between two consecutive clocks, at most one bit of each output pair changes.
- R10: Steps on one channel never change another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quad_i | input | 6 | Three quadrature input pairs |
| index_i | input | 1 | Index input |
| quad_o | output | 6 | Three divided quadrature output pairs |
| index_o | output | 1 | Stretched index output |

## Verification
A wrong step count stays hidden until the position crosses a multiple of 16. The fault then appears as an output pair that moves too early, too late or in the wrong direction. The bench therefore checks the outputs just before and just after each 16-step boundary, and during long random walks that include diagonal jumps. A wrong Gray step shows up on the clock after the strobe, as two bits flipping at once or as an out-of-order pair value. A fault in the index stretch shows only about 32 sample periods after the index falls, so the bench checks on both sides of that window.

// File: rtl/qdiv_pkg.sv
`timescale 1ns/1ps
package qdiv_pkg;
  // pair value {odd,even} -> phase index 0..3 along 00,01,11,10
  function automatic logic [1:0] gray_to_idx(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  function automatic logic [1:0] gray_next(input logic [1:0] g);
    return {g[0], ~g[1]};
  endfunction

  function automatic logic [1:0] gray_prev(input logic [1:0] g);
    return {~g[0], g[1]};
  endfunction
endpackage

// File: rtl/qdiv_sync.sv
`timescale 1ns/1ps
module qdiv_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/qdiv_strobe.sv
`timescale 1ns/1ps
module qdiv_strobe #(
  parameter int SAMPLE_DIV = 266
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic en_o
);
  localparam int CW = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_DIV - 1);

  logic [CW-1:0] div_q;
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      en_q  <= 1'b0;
    end else begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      en_q  <= (div_q == LAST);
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/qdiv_channel.sv
`timescale 1ns/1ps
module qdiv_channel
  import qdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_en_i,
  input  logic [1:0] quad_i,
  output logic [1:0] quad_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       top_q;
  logic [1:0]       delta;
  logic             step_up, step_dn;

  always_comb begin
    delta   = gray_to_idx(quad_i) - cnt_q[1:0];
    step_up = smp_en_i && (delta == 2'd1);
    step_dn = smp_en_i && (delta == 2'd3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      top_q <= '0;
    end else if (step_up) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) top_q <= gray_next(top_q);
    end else if (step_dn) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) top_q <= gray_prev(top_q);
    end
  end

  assign quad_o = top_q;
endmodule

// File: rtl/qdiv_stretch.sv
`timescale 1ns/1ps
module qdiv_stretch #(
  parameter int STRETCH_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_en_i,
  input  logic idx_i,
  output logic idx_o
);
  localparam int SW = $clog2(STRETCH_LEN + 1);
  localparam logic [SW-1:0] RELOAD = SW'(STRETCH_LEN);

  logic [SW-1:0] left_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      out_q  <= 1'b0;
    end else if (smp_en_i) begin
      if (idx_i) begin
        left_q <= RELOAD;
        out_q  <= 1'b1;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
        out_q  <= (left_q != SW'(1));
      end
    end
  end

  assign idx_o = out_q;
endmodule

// File: rtl/qdiv16_unit.sv
`timescale 1ns/1ps
module qdiv16_unit #(
  parameter int NUM_CH      = 3,
  parameter int CNT_W       = 4,
  parameter int SAMPLE_DIV  = 266,
  parameter int STRETCH_LEN = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NUM_CH-1:0]   quad_i,
  input  logic                  index_i,
  output logic [2*NUM_CH-1:0]   quad_o,
  output logic                  index_o
);
  localparam int QW = 2 * NUM_CH;

  logic [QW:0] sync_s;
  logic        smp_en;
  logic        idx_s;

  qdiv_sync #(.W(QW + 1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({index_i, quad_i}),
    .q_o   (sync_s)
  );

  assign idx_s = sync_s[QW];

  qdiv_strobe #(.SAMPLE_DIV(SAMPLE_DIV)) u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_o  (smp_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qdiv_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .smp_en_i(smp_en),
      .quad_i  (sync_s[2*c +: 2]),
      .quad_o  (quad_o[2*c +: 2])
    );
  end

  qdiv_stretch #(.STRETCH_LEN(STRETCH_LEN)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_en_i(smp_en),
    .idx_i   (idx_s),
    .idx_o   (index_o)
  );
endmodule

// File: rtl/qdiv16_checker.sv
`timescale 1ns/1ps
module qdiv16_checker #(
  parameter int NUM_CH = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                smp_en,
  input logic                idx_s,
  input logic [2*NUM_CH-1:0] quad_o,
  input logic                index_o
);
  // R8: strobe lasts one clock
  a_r8_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en |=> !smp_en);

  // R8: no output motion without a strobe
  a_r8_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en |=> ($stable(quad_o) && $stable(index_o)));

  // R7: sampled index high sets the output
  a_r7_index_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_en && idx_s) |=> index_o);

  // R7: output rises only from a sampled high index
  a_r7_index_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(index_o) |-> $past(smp_en && idx_s));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R9: Gray output, one bit per clock
    a_r9_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(quad_o[2*c +: 2] ^ $past(quad_o[2*c +: 2])) <= 1);
  end
endmodule

bind qdiv16_unit qdiv16_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .smp_en (smp_en),
  .idx_s  (idx_s),
  .quad_o (quad_o),
  .index_o(index_o)
);

// File: tb/tb_qdiv16_unit.sv
`timescale 1ns/1ps
module tb_qdiv16_unit;
  localparam int DIV = 4;
  localparam int SETTLE = 2 * DIV + 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] quad_i = '0;
  logic       index_i = 1'b0;
  logic [5:0] quad_o;
  logic       index_o;

  int tests = 0;
  int fails = 0;
  int pos[3];
  int ph[3];

  always #4 clk_i = ~clk_i;

  qdiv16_unit #(.SAMPLE_DIV(DIV)) dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .quad_i (quad_i),
    .index_i(index_i),
    .quad_o (quad_o),
    .index_o(index_o)
  );

  function automatic logic [1:0] g2(input int k);
    logic [1:0] v;
    v = 2'(k & 3);
    return v ^ (v >> 1);
  endfunction

  function automatic logic [1:0] exp_pair(input int c);
    return g2((pos[c] >> 4) & 3);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    quad_i  = '0;
    index_i = 1'b0;
    for (int c = 0; c < 3; c++) begin pos[c] = 0; ph[c] = 0; end
    repeat (3) @(negedge clk_i);
    chk("R6 outputs in reset", {1'b0, index_o, quad_o}, 8'h00);
    rst_ni = 1'b1;
    settle();
  endtask

  // drive channel c to phase p; model counts only +1/-1 moves
  task automatic put(input int c, input int p);
    int d;
    d = (p - pos[c]) & 3;
    if (d == 1) pos[c] = (pos[c] + 1) & 63;
    else if (d == 3) pos[c] = (pos[c] + 63) & 63;
    ph[c] = p & 3;
    quad_i[2*c +: 2] = g2(p);
    settle();
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 3; c++)
      chk(req, {6'd0, quad_o[2*c +: 2]}, {6'd0, exp_pair(c)});
  endtask

  task automatic t_forward();
    do_reset();
    for (int s = 1; s <= 64; s++) begin
      if (s == 16) begin
        // R8 latency: no change 2 clocks after driving
        @(negedge clk_i);
        quad_i[1:0] = g2(s);
        repeat (2) @(negedge clk_i);
        chk("R8 too early", {6'd0, quad_o[1:0]}, 8'h00);
        pos[0] = s;
        repeat (SETTLE - 2) @(negedge clk_i);
        chk("R8 within latency", {6'd0, quad_o[1:0]}, 8'h01);
      end else begin
        put(0, s);
      end
      if (s == 15) chk("R2 before boundary", {6'd0, quad_o[1:0]}, 8'h00);
      if (s == 32) chk("R2 second output step", {6'd0, quad_o[1:0]}, 8'h03);
      if (s == 48) chk("R2 third output step", {6'd0, quad_o[1:0]}, 8'h02);
      if (s == 63) chk("R5 last phase held", {6'd0, quad_o[1:0]}, 8'h02);
    end
    chk("R5 full cycle back to 00", {6'd0, quad_o[1:0]}, 8'h00);
  endtask

  task automatic t_reverse();
    do_reset();
    put(1, -1);
    chk("R3 first reverse step", {6'd0, quad_o[3:2]}, 8'h02);
    for (int s = 2; s <= 16; s++) put(1, -s);
    chk("R3 16 reverse steps", {6'd0, quad_o[3:2]}, 8'h02);
    put(1, -17);
    chk("R3 back again after 16 more", {6'd0, quad_o[3:2]}, 8'h03);
  endtask

  task automatic t_illegal();
    do_reset();
    for (int s = 1; s <= 15; s++) put(2, s);
    put(2, 15);
    chk("R4 same phase holds", {6'd0, quad_o[5:4]}, 8'h00);
    put(2, 17);
    chk("R4 diagonal jump holds", {6'd0, quad_o[5:4]}, 8'h00);
    put(2, 16);
    chk("R4 legal step from held position", {6'd0, quad_o[5:4]}, 8'h01);
  endtask

  task automatic t_indep();
    do_reset();
    for (int s = 1; s <= 16; s++) put(0, s);
    chk("R1 channel 0 on bits 1:0", {6'd0, quad_o[1:0]}, 8'h01);
    chk("R10 other channels untouched", {4'd0, quad_o[5:2]}, 8'h00);
    for (int s = 1; s <= 32; s++) put(2, -s);
    chk("R1 channel 2 on bits 5:4", {6'd0, quad_o[5:4]}, 8'h03);
    chk("R10 channel 0 kept", {6'd0, quad_o[1:0]}, 8'h01);
  endtask

  task automatic t_random();
    logic [5:0] prev;
    do_reset();
    prev = quad_o;
    for (int i = 0; i < 1500; i++) begin
      int c, r, mv;
      c  = int'($urandom_range(0, 2));
      r  = int'($urandom_range(0, 9));
      mv = (r < 5) ? 1 : (r < 8) ? -1 : (r < 9) ? 2 : 0;
      put(c, ph[c] + mv);
      for (int k = 0; k < 3; k++)
        if ($countones(quad_o[2*k +: 2] ^ prev[2*k +: 2]) > 1)
          chk("R9 two bits moved", {6'd0, quad_o[2*k +: 2]}, {6'd0, prev[2*k +: 2]});
      prev = quad_o;
      if (i % 50 == 49) check_all("R2 R3 R4 random walk");
    end
    check_all("R2 R3 R4 random walk end");
  endtask

  task automatic t_index();
    do_reset();
    chk("R7 idle low", {7'd0, index_o}, 8'h00);
    @(negedge clk_i); index_i = 1'b1;
    settle();
    chk("R7 set by index", {7'd0, index_o}, 8'h01);
    @(negedge clk_i); index_i = 1'b0;
    repeat (29 * DIV) @(negedge clk_i);
    chk("R7 still stretched", {7'd0, index_o}, 8'h01);
    repeat (7 * DIV) @(negedge clk_i);
    chk("R7 cleared after 32 samples", {7'd0, index_o}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_forward();
    t_reverse();
    t_illegal();
    t_indep();
    t_random();
    t_index();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule